// File: doc/BRIEF.md
# Destination Address to Security Entity Lookup

This block belongs to the transmit path of a link-layer encryption unit. For each outgoing frame it takes the 48-bit destination MAC address and returns the index of the virtual security entity whose keys will protect that frame. Different groups of destinations can therefore use different keys even though they leave through the same port.

A processor programs a small table over a 32-bit register bus. Each table entry holds three things:

- a destination address;
- a valid (in-use) flag;
- a 4-bit entity index.

A lookup request presents an address. One cycle later the block returns three outputs:

- a valid strobe;
- a hit flag;
- the entity index of the lowest-numbered in-use entry whose address matches.

When nothing matches, the block returns entity 0 with the hit flag low. This acts as a default route, not as an error. The register address space always has room for 64 entries, but only `NUM_IMPL` of them are built in hardware.

Top module: `dest_entity_cam`

## Requirements
- R1: After reset every entry is unused, `lk_valid` and `reg_rvalid` are low, and any lookup misses.
- R2: `lk_valid` is high exactly in the cycle after a cycle with `lk_req` high, and low otherwise.
- R3: A lookup whose 48-bit address equals the address of an in-use entry returns `lk_hit`=1 and that entry's 4-bit entity index.
- R4: A lookup that matches no in-use entry returns `lk_hit`=0 and `lk_entity`=0.
- R5: An entry whose in-use flag is 0 never matches, whatever address it holds.
- R6: If several in-use entries match, the entry with the lowest number supplies the result.
- R7: Several entries holding different addresses may map to the same entity index, and each of them hits.
- R8: Register address bits 7:2 select the entry. Bits 1:0 select the word within it:
  - 00: address bits 47:32, held in word bits 15:0; word bits 31:16 are ignored on write and read back as 0.
  - 01: address bits 31:0.
  - 10: the in-use flag, in word bit 0.
  - 11: the entity index, in word bits 3:0.
  Unused bits read back as 0.
- R9: Writes to entry numbers at or above `NUM_IMPL` change nothing, and reads from them return 0.
- R10: A read request returns its data on `reg_rdata` together with `reg_rvalid` in the following cycle.
- R11: A match needs all 48 address bits to agree; an address that differs only in its upper 16 bits misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_req | input | 1 | Lookup request strobe |
| lk_addr | input | 48 | Destination address to look up |
| lk_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | High when an in-use entry matched |
| lk_entity | output | 4 | Selected entity index (0 on a miss) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register word address (entry, word select) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_rvalid | output | 1 | Read data valid |

## Verification
The bench sets up a table that covers several corner cases at once:

- two in-use entries share one address, so a design that picks the highest-numbered match returns the wrong entity;
- an unused entry holds a live address, so a design that ignores the in-use flag hits on it;
- an entry deliberately maps to entity 0, so a design that derives the hit flag from the index cannot tell this hit from the default route.

Writes aimed past the implemented entries must leave the table unchanged. A decoder that truncates the entry number would alias those writes onto a real entry, and a later lookup would then hit or read back a changed value. Addresses that differ from a stored one only in the upper word catch a comparator that checks only the lower word. Writes with junk in the upper half of the high word, read back afterwards, catch a design that stores those bits.

// File: rtl/dcam_pkg.sv
package dcam_pkg;

    localparam int MAC_W  = 48;
    localparam int ENT_W  = 4;
    localparam int REG_W  = 32;
    localparam int HI_W   = MAC_W - REG_W;

    typedef enum logic [1:0] {
        W_MAC_HI = 2'b00,
        W_MAC_LO = 2'b01,
        W_USE    = 2'b10,
        W_ENT    = 2'b11
    } word_sel_e;

    typedef struct packed {
        logic             in_use;
        logic [ENT_W-1:0] ent;
        logic [MAC_W-1:0] mac;
    } entry_t;

endpackage

// File: rtl/dcam_entry_bank.sv
module dcam_entry_bank
    import dcam_pkg::*;
#(
    parameter int NUM_IMPL   = 8,
    parameter int ADDR_SPACE = 64,
    localparam int IDX_W     = $clog2(ADDR_SPACE),
    localparam int RA_W      = IDX_W + 2
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [RA_W-1:0]      reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 reg_rvalid,
    output entry_t [NUM_IMPL-1:0] tbl
);

    logic [IDX_W-1:0] sel_idx;
    word_sel_e        sel_word;
    logic             in_range;
    logic [REG_W-1:0] rd_word;

    assign sel_idx  = reg_addr[RA_W-1:2];
    assign sel_word = word_sel_e'(reg_addr[1:0]);
    assign in_range = ({1'b0, sel_idx} < (IDX_W+1)'(NUM_IMPL));

    // one write port per implemented entry; out-of-range numbers decode to none
    for (genvar g = 0; g < NUM_IMPL; g++) begin : g_entry
        logic wr_this;
        assign wr_this = reg_wr && (sel_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tbl[g] <= '0;
            end else if (wr_this) begin
                unique case (sel_word)
                    W_MAC_HI: tbl[g].mac[MAC_W-1:REG_W] <= reg_wdata[HI_W-1:0];
                    W_MAC_LO: tbl[g].mac[REG_W-1:0]     <= reg_wdata;
                    W_USE:    tbl[g].in_use             <= reg_wdata[0];
                    W_ENT:    tbl[g].ent                <= reg_wdata[ENT_W-1:0];
                endcase
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_IMPL; i++) begin
            if (sel_idx == IDX_W'(i)) begin
                unique case (sel_word)
                    W_MAC_HI: rd_word = {{(REG_W-HI_W){1'b0}}, tbl[i].mac[MAC_W-1:REG_W]};
                    W_MAC_LO: rd_word = tbl[i].mac[REG_W-1:0];
                    W_USE:    rd_word = {{(REG_W-1){1'b0}}, tbl[i].in_use};
                    W_ENT:    rd_word = {{(REG_W-ENT_W){1'b0}}, tbl[i].ent};
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) reg_rdata <= in_range ? rd_word : '0;
        end
    end

    p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);
    p_oor_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !in_range) |=> (reg_rdata == '0));
    p_oor_write_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !in_range) |=> $stable(tbl));
    p_hi_pad_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && sel_word == W_MAC_HI) |=> (reg_rdata[REG_W-1:HI_W] == '0));

endmodule

// File: rtl/dcam_match.sv
module dcam_match
    import dcam_pkg::*;
#(
    parameter int NUM_IMPL = 8
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  entry_t [NUM_IMPL-1:0] tbl,
    input  logic                  lk_req,
    input  logic [MAC_W-1:0]      lk_addr,
    output logic                  lk_valid,
    output logic                  lk_hit,
    output logic [ENT_W-1:0]      lk_entity
);

    logic [NUM_IMPL-1:0] hit_vec;
    logic [NUM_IMPL-1:0] use_vec;
    logic                any_hit;
    logic [ENT_W-1:0]    win_ent;

    for (genvar g = 0; g < NUM_IMPL; g++) begin : g_cmp
        assign use_vec[g] = tbl[g].in_use;
        assign hit_vec[g] = tbl[g].in_use && (tbl[g].mac == lk_addr);
    end

    // walk from the top down so the lowest-numbered match is written last
    always_comb begin
        any_hit = 1'b0;
        win_ent = '0;
        for (int i = NUM_IMPL-1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                win_ent = tbl[i].ent;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_valid  <= 1'b0;
            lk_hit    <= 1'b0;
            lk_entity <= '0;
        end else begin
            lk_valid <= lk_req;
            if (lk_req) begin
                lk_hit    <= any_hit;
                lk_entity <= win_ent;
            end
        end
    end

    p_miss_default_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit) |-> (lk_entity == '0));
    p_empty_table_misses_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && use_vec == '0) |=> (lk_valid && !lk_hit));

endmodule

// File: rtl/dest_entity_cam.sv
module dest_entity_cam
    import dcam_pkg::*;
#(
    parameter int NUM_IMPL   = 8,
    parameter int ADDR_SPACE = 64,
    localparam int RA_W      = $clog2(ADDR_SPACE) + 2
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [47:0]      lk_addr,
    output logic             lk_valid,
    output logic             lk_hit,
    output logic [3:0]       lk_entity,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             reg_rvalid
);

    entry_t [NUM_IMPL-1:0] tbl;

    dcam_entry_bank #(
        .NUM_IMPL   (NUM_IMPL),
        .ADDR_SPACE (ADDR_SPACE)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .tbl        (tbl)
    );

    dcam_match #(
        .NUM_IMPL (NUM_IMPL)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .tbl       (tbl),
        .lk_req    (lk_req),
        .lk_addr   (lk_addr),
        .lk_valid  (lk_valid),
        .lk_hit    (lk_hit),
        .lk_entity (lk_entity)
    );

    p_valid_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_valid);
    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_valid);

endmodule

// File: tb/tb_dest_entity_cam.sv
module tb_dest_entity_cam;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 8;

    localparam logic [47:0] MAC_A = 48'h0011_2233_4455;
    localparam logic [47:0] MAC_B = 48'h00AA_BBCC_DDEE;
    localparam logic [47:0] MAC_C = 48'h0102_0304_0506;
    localparam logic [47:0] MAC_D = 48'h7777_8888_9999;
    localparam logic [47:0] MAC_E = 48'hFEDC_BA98_7654;
    localparam logic [47:0] MAC_F = 48'h1234_5678_9ABC;
    localparam logic [47:0] MAC_G = 48'h0012_2233_4455;

    // {expected hit, expected entity, address}
    localparam logic [52:0] VEC [N_VEC] = '{
        {1'b1, 4'd3, MAC_A},
        {1'b1, 4'd5, MAC_B},
        {1'b1, 4'd5, MAC_C},
        {1'b0, 4'd0, MAC_D},
        {1'b1, 4'd0, MAC_E},
        {1'b0, 4'd0, MAC_F},
        {1'b0, 4'd0, MAC_G},
        {1'b0, 4'd0, 48'h0}
    };
    localparam string VEC_REQ [N_VEC] = '{"R6", "R7", "R3", "R5", "R3", "R9", "R11", "R5"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [47:0] lk_addr = '0;
    logic        lk_valid, lk_hit;
    logic [3:0]  lk_entity;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dest_entity_cam dut (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_addr(lk_addr),
        .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_entity(lk_entity),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int ent, input int wsel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'((ent << 2) | wsel); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic prog(input int ent, input logic [47:0] mac, input logic [3:0] e, input bit use_bit);
        wr(ent, 0, {16'hABCD, mac[47:32]});
        wr(ent, 1, mac[31:0]);
        wr(ent, 3, {28'hFFFFFFF, e});
        wr(ent, 2, {31'h7FFF_FFFE, use_bit});
    endtask

    task automatic rd_chk(input string req, input int ent, input int wsel, input logic [31:0] exp);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 8'((ent << 2) | wsel);
        @(negedge clk);
        reg_rd = 1'b0;
        chk(req, "rvalid", 64'(reg_rvalid), 64'd1);
        chk(req, "rdata", 64'(reg_rdata), 64'(exp));
    endtask

    task automatic look(input string req, input logic [47:0] mac, input bit eh, input logic [3:0] ee);
        @(negedge clk);
        lk_req = 1'b1; lk_addr = mac;
        @(negedge clk);
        lk_req = 1'b0;
        chk(req, "valid", 64'(lk_valid), 64'd1);
        chk(req, "hit", 64'(lk_hit), 64'(eh));
        chk(req, "entity", 64'(lk_entity), 64'(ee));
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "lk_valid in reset", 64'(lk_valid), 64'd0);
        chk("R1", "rvalid in reset", 64'(reg_rvalid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "lk_valid after reset", 64'(lk_valid), 64'd0);
        look("R1", MAC_A, 1'b0, 4'd0);
        look("R1", 48'h0, 1'b0, 4'd0);
        @(negedge clk);
        chk("R2", "valid without request", 64'(lk_valid), 64'd0);

        prog(0, MAC_A, 4'd3, 1'b1);
        prog(1, MAC_B, 4'd5, 1'b1);
        prog(2, MAC_A, 4'd7, 1'b1);
        prog(3, MAC_C, 4'd5, 1'b1);
        prog(4, MAC_D, 4'd9, 1'b0);
        prog(5, MAC_E, 4'd0, 1'b1);
        prog(10, MAC_F, 4'd2, 1'b1);
        prog(40, MAC_F, 4'd2, 1'b1);

        for (int i = 0; i < N_VEC; i++) begin
            look(VEC_REQ[i], VEC[i][47:0], VEC[i][52], VEC[i][51:48]);
        end

        rd_chk("R8", 0, 0, 32'h0000_0011);
        rd_chk("R8", 0, 1, 32'h2233_4455);
        rd_chk("R8", 0, 2, 32'h0000_0001);
        rd_chk("R8", 0, 3, 32'h0000_0003);
        rd_chk("R8", 4, 2, 32'h0000_0000);
        rd_chk("R8", 6, 1, 32'h0000_0000);
        rd_chk("R9", 10, 1, 32'h0000_0000);
        rd_chk("R9", 10, 2, 32'h0000_0000);
        rd_chk("R9", 2, 1, 32'h2233_4455);

        // clear entry 0: entry 2 now supplies the result for the shared address
        wr(0, 2, 32'h0);
        look("R5", MAC_A, 1'b1, 4'd7);
        // back-to-back requests each produce a result
        @(negedge clk);
        lk_req = 1'b1; lk_addr = MAC_B;
        @(negedge clk);
        lk_addr = MAC_D;
        chk("R2", "b2b first valid", 64'(lk_valid), 64'd1);
        chk("R3", "b2b first entity", 64'(lk_entity), 64'd5);
        @(negedge clk);
        lk_req = 1'b0;
        chk("R2", "b2b second valid", 64'(lk_valid), 64'd1);
        chk("R4", "b2b second hit", 64'(lk_hit), 64'd0);
        @(negedge clk);
        chk("R2", "valid drops", 64'(lk_valid), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule